// File: doc/BRIEF.md
# Host Memory Window with Auto-Increment

This block gives a host processor byte-wide I/O access to a small embedded controller's local RAM, with no help from the controller's processor. It occupies sixteen byte offsets. The host loads a 16-bit pointer register. That register names a memory region, a word offset within the region and an access width. The host then reads or writes the four bytes of the selected 32-bit word through four data lanes. In the streaming mode the pointer steps to the next word each time the top lane is touched. The host can therefore pull a block of memory with a simple loop of byte reads.

The same offset space also holds two mailbox bytes, one for each direction, and a 16-bit interrupt source register with a matching mask. These raise a host interrupt line, and give the controller a doorbell flag with its own clear strobe. The controller fills the RAM through its own word write port. The block contains a two-region RAM model that is read every cycle at the current pointer. Host lane reads therefore see the addressed word one clock after the pointer or the memory changes.

Top module: `mw_window`

## Requirements
- R1: After reset the pointer, both mailboxes, the doorbell flag and all source bits are 0, both mask bytes read 0xFF, and `host_irq` is 0. Offset 0x0C reads the `APP_ID` parameter (default 0xA5), and offsets 0x0D to 0x0F read 0.
- R2: Offsets 0x02 and 0x03 hold the low and high bytes of the pointer and can be written and read back. Pointer bit 15 is the region, bits [14:2] are the word offset, and bits [1:0] are the mode: 0 byte, 1 half-word, 2 word, 3 word with auto-increment.
- R3: A host read of offset 0x04+n returns bits [8n+7:8n] of the RAM word at index {region, word offset[WORD_AW-1:0]}. This holds from the second cycle after the pointer last changed.
- R4: A word that the controller writes through `ec_mem_*` becomes visible to host lane reads with no further controller action.
- R5: In mode 3, a host read or write of offset 0x07 advances the word offset by one. The offset wraps from 0x1FFF to 0, and the region and mode bits stay unchanged.
- R6: Accesses to lanes 0 to 2 in mode 3, and to any lane in modes 0 to 2, leave the pointer unchanged.
- R7: In mode 0, a host write to lane n writes only byte n of the addressed word.
- R8: In mode 1, a write to an even lane is held only in staging. A write to an odd lane commits that lane and the lane below it, and no other lanes.
- R9: In modes 2 and 3, writes to lanes 0 to 2 are only staged. A write to lane 3 commits all four staged bytes together.
- R10: A host write to 0x00 stores the byte on `ec_h2c_mbox` and sets `ec_h2c_flag`. `ec_h2c_clr` clears the flag, and a host write in the same cycle wins. The host reads the byte back at 0x00.
- R11: A controller write through `ec_c2h_we` stores the byte that the host reads at 0x01 and sets source bit 0. Host writes to 0x01 are ignored.
- R12: Source bits (0x08 low, 0x09 high) are set by `ec_src_set`, and a host write of 1 clears a bit. If a set and a clear meet in the same cycle, the set wins.
- R13: Mask bytes at 0x0A and 0x0B can be read and written. `host_irq` is 1 exactly when some source bit is 1 and its mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host byte write strobe |
| host_rd | input | 1 | Host byte read strobe |
| host_off | input | 4 | Host register offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte for the current offset |
| host_irq | output | 1 | Host interrupt request |
| ec_h2c_mbox | output | 8 | Byte last written by the host to the inbound mailbox |
| ec_h2c_flag | output | 1 | Doorbell flag to the controller |
| ec_h2c_clr | input | 1 | Controller clears the doorbell flag |
| ec_c2h_we | input | 1 | Controller writes the outbound mailbox |
| ec_c2h_data | input | 8 | Outbound mailbox byte |
| ec_src_set | input | 16 | Controller pulses to set source bits |
| ec_mem_we | input | 1 | Controller RAM word write |
| ec_mem_addr | input | WORD_AW+1 | Controller RAM index {region, word} |
| ec_mem_wdata | input | 32 | Controller RAM write word |

## Verification
Two pairs of events can land on the same edge. In the first, the controller writes the outbound mailbox while the host writes 1 to source bit 0. In the second, the controller clears the doorbell while the host writes the inbound mailbox. The bench drives each pair in one cycle and expects the bit or flag to remain set afterwards. The bench also reads pointer bytes straight after a top-lane access, so that the streaming step and the wrap at the end of the offset field are judged against values worked out from the mode and region.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [1:0] {
        ACC_B8      = 2'd0,
        ACC_B16     = 2'd1,
        ACC_W32     = 2'd2,
        ACC_W32_INC = 2'd3
    } acc_e;

    localparam logic [3:0] OFF_H2C = 4'h0;
    localparam logic [3:0] OFF_C2H = 4'h1;
    localparam logic [3:0] OFF_ALO = 4'h2;
    localparam logic [3:0] OFF_AHI = 4'h3;
    localparam logic [3:0] OFF_SLO = 4'h8;
    localparam logic [3:0] OFF_SHI = 4'h9;
    localparam logic [3:0] OFF_MLO = 4'hA;
    localparam logic [3:0] OFF_MHI = 4'hB;
    localparam logic [3:0] OFF_ID  = 4'hC;

    typedef struct packed {
        logic [15:0] addr;
        logic [7:0]  h2c;
        logic        h2c_flag;
        logic [7:0]  c2h;
        logic [31:0] stage;
    } win_state_t;

endpackage

// File: rtl/mw_ram.sv
module mw_ram #(
    parameter int RAM_AW = 7
) (
    input  logic              clk,
    input  logic              h_we,
    input  logic [3:0]        h_be,
    input  logic [RAM_AW-1:0] h_idx,
    input  logic [31:0]       h_wdata,
    input  logic              c_we,
    input  logic [RAM_AW-1:0] c_idx,
    input  logic [31:0]       c_wdata,
    input  logic [RAM_AW-1:0] r_idx,
    output logic [31:0]       r_word
);
    localparam int DEPTH = 1 << RAM_AW;

    logic [31:0] mem [DEPTH];

    // Host byte writes follow the controller word write, so the host wins per lane.
    always_ff @(posedge clk) begin
        if (c_we) mem[c_idx] <= c_wdata;
        if (h_we) begin
            for (int l = 0; l < 4; l++) begin
                if (h_be[l]) mem[h_idx][8*l +: 8] <= h_wdata[8*l +: 8];
            end
        end
        r_word <= mem[r_idx];
    end

endmodule

// File: rtl/mw_irq.sv
module mw_irq
    import mw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [3:0]  off,
    input  logic [7:0]  wdata,
    input  logic [15:0] set_vec,
    output logic [15:0] src,
    output logic [15:0] mask,
    output logic        irq
);
    typedef struct packed {
        logic [15:0] src;
        logic [15:0] mask;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            unique case (off)
                OFF_SLO: st_d.src[7:0]   = st_q.src[7:0]  & ~wdata;
                OFF_SHI: st_d.src[15:8]  = st_q.src[15:8] & ~wdata;
                OFF_MLO: st_d.mask[7:0]  = wdata;
                OFF_MHI: st_d.mask[15:8] = wdata;
                default: ;
            endcase
        end
        // setting is applied last so a simultaneous clear loses
        st_d.src = st_d.src | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.src  <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign src  = st_q.src;
    assign mask = st_q.mask;
    assign irq  = |(st_q.src & ~st_q.mask);

endmodule

// File: rtl/mw_window.sv
module mw_window
    import mw_pkg::*;
#(
    parameter int          WORD_AW = 6,
    parameter logic [7:0]  APP_ID  = 8'hA5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_wr,
    input  logic                 host_rd,
    input  logic [3:0]           host_off,
    input  logic [7:0]           host_wdata,
    output logic [7:0]           host_rdata,
    output logic                 host_irq,
    output logic [7:0]           ec_h2c_mbox,
    output logic                 ec_h2c_flag,
    input  logic                 ec_h2c_clr,
    input  logic                 ec_c2h_we,
    input  logic [7:0]           ec_c2h_data,
    input  logic [15:0]          ec_src_set,
    input  logic                 ec_mem_we,
    input  logic [WORD_AW:0]     ec_mem_addr,
    input  logic [31:0]          ec_mem_wdata
);
    localparam int RAM_AW = WORD_AW + 1;

    win_state_t         st_d, st_q;
    logic [15:0]        addr_cur;
    logic [15:0]        src_cur, mask_cur;
    acc_e               acc;
    logic               is_lane;
    logic [1:0]         lane;
    logic               ram_we;
    logic [3:0]         ram_be;
    logic [31:0]        ram_wdata, stage_new, rd_word;
    logic [RAM_AW-1:0]  ram_idx;

    assign addr_cur = st_q.addr;
    assign acc      = acc_e'(st_q.addr[1:0]);
    assign is_lane  = (host_off[3:2] == 2'b01);
    assign lane     = host_off[1:0];
    assign ram_idx  = {st_q.addr[15], st_q.addr[WORD_AW+1:2]};

    always_comb begin
        st_d      = st_q;
        ram_we    = 1'b0;
        ram_be    = 4'b0000;
        stage_new = st_q.stage;
        stage_new[{lane, 3'b000} +: 8] = host_wdata;
        ram_wdata = stage_new;

        if (ec_h2c_clr) st_d.h2c_flag = 1'b0;
        if (ec_c2h_we)  st_d.c2h      = ec_c2h_data;

        if (host_wr) begin
            if (is_lane) begin
                st_d.stage = stage_new;
                unique case (acc)
                    ACC_B8: begin
                        ram_we = 1'b1;
                        ram_be = 4'b0001 << lane;
                    end
                    ACC_B16: begin
                        ram_we = lane[0];
                        ram_be = lane[1] ? 4'b1100 : 4'b0011;
                    end
                    default: begin
                        ram_we = (lane == 2'd3);
                        ram_be = 4'b1111;
                    end
                endcase
            end else begin
                unique case (host_off)
                    OFF_H2C: begin
                        st_d.h2c      = host_wdata;
                        st_d.h2c_flag = 1'b1;
                    end
                    OFF_ALO: st_d.addr[7:0]  = host_wdata;
                    OFF_AHI: st_d.addr[15:8] = host_wdata;
                    default: ;
                endcase
            end
        end

        // streaming step: only word offset moves, region and mode are kept
        if ((host_wr || host_rd) && is_lane && lane == 2'd3 && acc == ACC_W32_INC) begin
            st_d.addr[14:2] = st_q.addr[14:2] + 13'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        host_rdata = 8'h00;
        if (is_lane) begin
            host_rdata = rd_word[{lane, 3'b000} +: 8];
        end else begin
            unique case (host_off)
                OFF_H2C: host_rdata = st_q.h2c;
                OFF_C2H: host_rdata = st_q.c2h;
                OFF_ALO: host_rdata = st_q.addr[7:0];
                OFF_AHI: host_rdata = st_q.addr[15:8];
                OFF_SLO: host_rdata = src_cur[7:0];
                OFF_SHI: host_rdata = src_cur[15:8];
                OFF_MLO: host_rdata = mask_cur[7:0];
                OFF_MHI: host_rdata = mask_cur[15:8];
                OFF_ID:  host_rdata = APP_ID;
                default: host_rdata = 8'h00;
            endcase
        end
    end

    assign ec_h2c_mbox = st_q.h2c;
    assign ec_h2c_flag = st_q.h2c_flag;

    mw_ram #(.RAM_AW(RAM_AW)) u_ram (
        .clk     (clk),
        .h_we    (ram_we),
        .h_be    (ram_be),
        .h_idx   (ram_idx),
        .h_wdata (ram_wdata),
        .c_we    (ec_mem_we),
        .c_idx   (ec_mem_addr),
        .c_wdata (ec_mem_wdata),
        .r_idx   (ram_idx),
        .r_word  (rd_word)
    );

    mw_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (host_wr),
        .off     (host_off),
        .wdata   (host_wdata),
        .set_vec (ec_src_set | {15'd0, ec_c2h_we}),
        .src     (src_cur),
        .mask    (mask_cur),
        .irq     (host_irq)
    );

endmodule

// File: rtl/mw_window_chk.sv
module mw_window_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr,
    input logic        host_rd,
    input logic [3:0]  host_off,
    input logic [15:0] addr_cur,
    input logic        ram_we,
    input logic [3:0]  ram_be,
    input logic        ec_c2h_we,
    input logic [15:0] src_cur,
    input logic        ec_h2c_flag
);
    logic acc_any;
    assign acc_any = host_wr || host_rd;

    a_r5_stream_step: assert property (@(posedge clk) disable iff (!rst_n)
        acc_any && host_off == 4'h7 && addr_cur[1:0] == 2'd3
        |=> addr_cur[14:2] == $past(addr_cur[14:2]) + 13'd1
            && addr_cur[15] == $past(addr_cur[15]) && addr_cur[1:0] == 2'd3);

    a_r6_pointer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        acc_any && host_off[3:2] == 2'b01
        && !(host_off[1:0] == 2'd3 && addr_cur[1:0] == 2'd3)
        |=> $stable(addr_cur));

    a_r7_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we && addr_cur[1:0] == 2'd0 |-> $countones(ram_be) == 1);

    a_r8_half_pair: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we && addr_cur[1:0] == 2'd1 |-> (ram_be == 4'b0011 || ram_be == 4'b1100));

    a_r9_word_on_top: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we && addr_cur[1] |-> ram_be == 4'b1111 && host_off == 4'h7);

    a_r10_doorbell: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && host_off == 4'h0 |=> ec_h2c_flag);

    a_r11_c2h_source: assert property (@(posedge clk) disable iff (!rst_n)
        ec_c2h_we |=> src_cur[0]);

endmodule

bind mw_window mw_window_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_off    (host_off),
    .addr_cur    (addr_cur),
    .ram_we      (ram_we),
    .ram_be      (ram_be),
    .ec_c2h_we   (ec_c2h_we),
    .src_cur     (src_cur),
    .ec_h2c_flag (ec_h2c_flag)
);

// File: tb/mw_window_bench.sv
module mw_window_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WAW = 6;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_wr, host_rd;
    logic [3:0]  host_off;
    logic [7:0]  host_wdata, host_rdata;
    logic        host_irq;
    logic [7:0]  ec_h2c_mbox;
    logic        ec_h2c_flag, ec_h2c_clr, ec_c2h_we;
    logic [7:0]  ec_c2h_data;
    logic [15:0] ec_src_set;
    logic        ec_mem_we;
    logic [WAW:0] ec_mem_addr;
    logic [31:0] ec_mem_wdata;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mw_window #(.WORD_AW(WAW), .APP_ID(8'hA5)) u_mw_window (
        .clk, .rst_n, .host_wr, .host_rd, .host_off, .host_wdata, .host_rdata,
        .host_irq, .ec_h2c_mbox, .ec_h2c_flag, .ec_h2c_clr, .ec_c2h_we,
        .ec_c2h_data, .ec_src_set, .ec_mem_we, .ec_mem_addr, .ec_mem_wdata
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [3:0] off, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_off = off; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic io_read(input logic [3:0] off, output logic [7:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_off = off;
        #(CLK_PERIOD/4);
        d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_rd(input string req, input logic [3:0] off, input logic [7:0] exp);
        logic [7:0] d;
        io_read(off, d);
        check(req, {24'd0, d}, {24'd0, exp});
    endtask

    task automatic ec_load(input logic [WAW:0] idx, input logic [31:0] w);
        @(negedge clk);
        ec_mem_we = 1'b1; ec_mem_addr = idx; ec_mem_wdata = w;
        @(negedge clk);
        ec_mem_we = 1'b0;
    endtask

    task automatic set_ptr(input logic [15:0] p);
        io_write(4'h2, p[7:0]);
        io_write(4'h3, p[15:8]);
    endtask

    task automatic t_reset;
        expect_rd("R1 ptr lo", 4'h2, 8'h00);
        expect_rd("R1 ptr hi", 4'h3, 8'h00);
        expect_rd("R1 h2c", 4'h0, 8'h00);
        expect_rd("R1 c2h", 4'h1, 8'h00);
        expect_rd("R1 src lo", 4'h8, 8'h00);
        expect_rd("R1 mask lo", 4'hA, 8'hFF);
        expect_rd("R1 mask hi", 4'hB, 8'hFF);
        expect_rd("R1 id", 4'hC, 8'hA5);
        expect_rd("R1 hole", 4'hE, 8'h00);
        check("R1 irq", {31'd0, host_irq}, 32'd0);
        check("R1 flag", {31'd0, ec_h2c_flag}, 32'd0);
    endtask

    task automatic t_read_window;
        ec_load(7'h05, 32'h44332211);
        ec_load(7'h45, 32'hDDCCBBAA);
        set_ptr(16'h0016);
        expect_rd("R2 ptr readback", 4'h2, 8'h16);
        expect_rd("R3 lane0", 4'h4, 8'h11);
        expect_rd("R3 lane1", 4'h5, 8'h22);
        expect_rd("R3 lane2", 4'h6, 8'h33);
        expect_rd("R3 lane3", 4'h7, 8'h44);
        expect_rd("R6 mode2 no step", 4'h2, 8'h16);
        io_write(4'h3, 8'h80);
        expect_rd("R2 region bit", 4'h3, 8'h80);
        expect_rd("R3 region1 lane0", 4'h4, 8'hAA);
        ec_load(7'h45, 32'h99887766);
        @(negedge clk);
        expect_rd("R4 ctl update seen", 4'h5, 8'h77);
    endtask

    task automatic t_stream;
        ec_load(7'h00, 32'h03020100);
        ec_load(7'h01, 32'h07060504);
        set_ptr(16'h0003);
        expect_rd("R6 lane0 no step", 4'h4, 8'h00);
        expect_rd("R6 ptr after lane0", 4'h2, 8'h03);
        expect_rd("R5 lane3 data", 4'h7, 8'h03);
        expect_rd("R5 ptr stepped", 4'h2, 8'h07);
        expect_rd("R5 next word", 4'h4, 8'h04);
        ec_load(7'h3F, 32'h55667788);
        set_ptr(16'h7FFF);
        expect_rd("R5 last word", 4'h7, 8'h55);
        expect_rd("R5 wrap lo", 4'h2, 8'h03);
        expect_rd("R5 wrap hi", 4'h3, 8'h00);
        ec_load(7'h7F, 32'h11223344);
        ec_load(7'h40, 32'hC3C2C1C0);
        set_ptr(16'hFFFF);
        expect_rd("R5 region1 last", 4'h7, 8'h11);
        expect_rd("R5 region kept", 4'h3, 8'h80);
        expect_rd("R5 region1 word0", 4'h4, 8'hC0);
    endtask

    task automatic t_write_modes;
        ec_load(7'h08, 32'hAABBCCDD);
        set_ptr(16'h0020);
        io_write(4'h5, 8'h5A);
        expect_rd("R7 lane0 kept", 4'h4, 8'hDD);
        expect_rd("R7 lane1 written", 4'h5, 8'h5A);
        expect_rd("R7 lane2 kept", 4'h6, 8'hBB);
        ec_load(7'h09, 32'h11111111);
        set_ptr(16'h0025);
        io_write(4'h6, 8'h22);
        expect_rd("R8 even lane staged", 4'h6, 8'h11);
        io_write(4'h7, 8'h33);
        expect_rd("R8 pair lane2", 4'h6, 8'h22);
        expect_rd("R8 pair lane3", 4'h7, 8'h33);
        expect_rd("R8 lane1 kept", 4'h5, 8'h11);
        ec_load(7'h0A, 32'hFFFFFFFF);
        set_ptr(16'h002B);
        io_write(4'h4, 8'h01);
        io_write(4'h5, 8'h02);
        io_write(4'h6, 8'h03);
        expect_rd("R9 staged not written", 4'h4, 8'hFF);
        io_write(4'h7, 8'h04);
        expect_rd("R9 ptr step on write", 4'h2, 8'h2F);
        set_ptr(16'h002A);
        expect_rd("R9 lane0", 4'h4, 8'h01);
        expect_rd("R9 lane1", 4'h5, 8'h02);
        expect_rd("R9 lane3", 4'h7, 8'h04);
    endtask

    task automatic t_doorbell;
        io_write(4'h0, 8'h3C);
        check("R10 mbox out", {24'd0, ec_h2c_mbox}, 32'h3C);
        check("R10 flag set", {31'd0, ec_h2c_flag}, 32'd1);
        expect_rd("R10 readback", 4'h0, 8'h3C);
        @(negedge clk); ec_h2c_clr = 1'b1;
        @(negedge clk); ec_h2c_clr = 1'b0;
        check("R10 flag cleared", {31'd0, ec_h2c_flag}, 32'd0);
        @(negedge clk);
        ec_h2c_clr = 1'b1; host_wr = 1'b1; host_off = 4'h0; host_wdata = 8'h5D;
        @(negedge clk);
        ec_h2c_clr = 1'b0; host_wr = 1'b0;
        check("R10 host wins clear", {31'd0, ec_h2c_flag}, 32'd1);
    endtask

    task automatic t_outbound;
        @(negedge clk); ec_c2h_we = 1'b1; ec_c2h_data = 8'h77;
        @(negedge clk); ec_c2h_we = 1'b0;
        expect_rd("R11 c2h data", 4'h1, 8'h77);
        expect_rd("R11 src bit0", 4'h8, 8'h01);
        check("R13 masked no irq", {31'd0, host_irq}, 32'd0);
        io_write(4'h1, 8'h12);
        expect_rd("R11 host write ignored", 4'h1, 8'h77);
        io_write(4'hA, 8'hFE);
        expect_rd("R13 mask readback", 4'hA, 8'hFE);
        check("R13 irq unmasked", {31'd0, host_irq}, 32'd1);
        io_write(4'h8, 8'h01);
        check("R12 cleared irq", {31'd0, host_irq}, 32'd0);
        @(negedge clk);
        ec_c2h_we = 1'b1; ec_c2h_data = 8'h78;
        host_wr = 1'b1; host_off = 4'h8; host_wdata = 8'h01;
        @(negedge clk);
        ec_c2h_we = 1'b0; host_wr = 1'b0;
        expect_rd("R12 set beats clear", 4'h8, 8'h01);
        io_write(4'h8, 8'h01);
        expect_rd("R12 clear bit0", 4'h8, 8'h00);
        @(negedge clk); ec_src_set = 16'h0100;
        @(negedge clk); ec_src_set = 16'h0000;
        expect_rd("R12 high src", 4'h9, 8'h01);
        check("R13 high masked", {31'd0, host_irq}, 32'd0);
        io_write(4'hB, 8'hFE);
        check("R13 high unmasked", {31'd0, host_irq}, 32'd1);
        io_write(4'h9, 8'h01);
        check("R12 high cleared", {31'd0, host_irq}, 32'd0);
    endtask

    initial begin
        host_wr = 0; host_rd = 0; host_off = 0; host_wdata = 0;
        ec_h2c_clr = 0; ec_c2h_we = 0; ec_c2h_data = 0; ec_src_set = 0;
        ec_mem_we = 0; ec_mem_addr = 0; ec_mem_wdata = 0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read_window();
        t_stream();
        t_write_modes();
        t_doorbell();
        t_outbound();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule